// File: doc/BRIEF.md
# Three-Wire Serial Clock-Chip Master

This block is the host side of a half-duplex serial link to a timekeeping chip. The link has three wires: an active-high chip enable, a serial clock that the block generates, and one data line that both ends share. The block brings the shared line out as three plain signals, `dio_out`, `dio_oe` and `dio_in`, and the pad ring joins them into one tristate pin. A host starts a transaction by raising `req_valid` for one cycle while `busy` is low. It supplies an operation code, a register address and up to eight write bytes. The block shifts a command byte and then the data bytes onto the line, least significant bit first. On reads it releases the line after the command so that the chip can answer, and it gathers the returned bits. At the end it presents the read bytes together with a one-cycle `done` pulse.

The serial clock period is two half periods. Each half period is `half_div` system cycles long, with 0 treated as 1. At a 50 MHz system clock, a setting of 13 or more stays below 2 MHz and a setting of 50 gives 500 kHz. `half_div` must stay stable while `busy` is high. The burst operations always address the chip's burst register, address 0x1F, and move eight data bytes after one command byte. The single operations move one byte at the given address.

The controller is one state machine with these states:
- IDLE: the bus is quiet and the block accepts a request.
- CMD_LO and CMD_HI: the low and high halves of each command bit.
- WR_LO and WR_HI: the low and high halves of each write data bit.
- RD_LO and RD_HI: the low and high halves of each read data bit.
- HOLD: a half period with the clock low and chip enable still high.
- GAP: two half periods with chip enable low.

The transitions are these:
- IDLE goes to CMD_LO when a request is accepted.
- LO goes to HI on each half-period tick.
- CMD_HI goes back to CMD_LO until the eighth command bit. After that bit it goes to WR_LO for a write or to RD_LO for a read.
- WR_HI and RD_HI go back to their LO state until the last bit of the last byte, and then go to HOLD.
- HOLD goes to GAP.
- GAP goes to IDLE after its second tick.

Top module: `rtc3w_master`

## Requirements
- R1: While reset is asserted, `ce`, `sclk`, `dio_oe`, `busy` and `done` are all 0.
- R2: The command byte leaves the block LSB first. Bit 7 is 1, bit 6 is 0, bits 5:1 hold the address, and bit 0 is 1 for a read and 0 for a write. The burst operations put address 0x1F in the command whatever `req_addr` holds.
- R3: `req_op` encodes the operation: 0 is a single write, 1 is a single read, 2 is a burst write and 3 is a burst read. A single operation moves 1 data byte and a burst moves 8. Data byte k travels in bits 8k+7:8k of `req_wdata` and of `rdata`. A single write sends only byte 0, and a single read returns zeros in bytes 1 to 7.
- R4: `dio_out` changes only while `sclk` is low, so the chip can sample it on each rising edge.
- R5: The block samples `dio_in` at the end of each low half of a read bit. `dio_oe` falls only together with a falling `sclk` edge. On reads, `dio_oe` is 0 from the falling edge that ends the eighth command clock until the end of the transaction. On command and write bits, `dio_oe` is 1 at every rising edge.
- R6: `ce` stays high from the first command bit through the last data bit and one more half period, and only while `busy` is high. `sclk` rises exactly 8 + 8·(data bytes) times while `ce` is high.
- R7: Every serial half period lasts max(`half_div`,1) system cycles, so `ce` is high for (16·bytes + 17)·max(`half_div`,1) cycles.
- R8: After each transaction, `ce` stays low for 2·max(`half_div`,1) cycles before `busy` falls. `sclk` is low whenever `ce` is low.
- R9: A request is accepted only while `busy` is low, and `busy` is high in the next cycle. A `req_valid` raised while `busy` is high starts no transaction and leaves the running one unchanged.
- R10: `done` is a one-cycle pulse in the cycle after `ce` falls. `rdata` holds the gathered bytes from that cycle until the next `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 2 | Operation code (R3) |
| req_addr | input | 5 | Register address for single operations |
| req_wdata | input | 64 | Write bytes, byte k in bits 8k+7:8k |
| half_div | input | 8 | System cycles per serial half period |
| busy | output | 1 | Transaction or inter-transaction gap in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rdata | output | 64 | Read bytes, byte k in bits 8k+7:8k |
| ce | output | 1 | Active-high chip enable |
| sclk | output | 1 | Serial clock, idles low |
| dio_out | output | 1 | Data line value driven by the block |
| dio_oe | output | 1 | Data line output enable |
| dio_in | input | 1 | Data line value seen at the pad |

## Verification
The bench builds the block with its default parameters: a 5-bit address, 8-bit bytes and an 8-byte burst. It sweeps `half_div` over 0, 1, 2 and 3, which covers the degenerate zero setting and the one-cycle half period where a low half and a high half each last a single cycle. For each setting it writes and reads back every single-access address below the burst register, and it runs a burst write and a burst read with a non-burst `req_addr`. A final pass at `half_div` = 50 runs the 500 kHz case. A behavioural chip model in the bench decodes the command, stores the writes and answers the reads. The bench compares the cycle counts of `ce` and `busy` against closed-form expectations.

// File: rtl/rtc3w_pkg.sv
package rtc3w_pkg;

    typedef enum logic [1:0] {
        OP_WR_ONE   = 2'd0,
        OP_RD_ONE   = 2'd1,
        OP_WR_BURST = 2'd2,
        OP_RD_BURST = 2'd3
    } rtc3w_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD_LO,
        ST_CMD_HI,
        ST_WR_LO,
        ST_WR_HI,
        ST_RD_LO,
        ST_RD_HI,
        ST_HOLD,
        ST_GAP
    } rtc3w_state_e;

endpackage

// File: rtl/rtc3w_tick.sv
module rtc3w_tick #(
    parameter int HDIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HDIV_W-1:0] half_div,
    output logic              tick
);
    logic [HDIV_W-1:0] cnt_q;
    logic [HDIV_W-1:0] limit;

    // a zero setting behaves as a one-cycle half period
    assign limit = (half_div == '0) ? '0 : half_div - HDIV_W'(1);
    assign tick  = run && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= limit;
        end else begin
            cnt_q <= cnt_q - HDIV_W'(1);
        end
    end
endmodule

// File: rtl/rtc3w_rxcap.sv
module rtc3w_rxcap #(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              cap,
    input  logic [IDX_W-1:0]  idx,
    input  logic              din,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] data_q;

    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q[g] <= 1'b0;
            end else if (clear) begin
                data_q[g] <= 1'b0;
            end else if (cap && (idx == IDX_W'(g))) begin
                data_q[g] <= din;
            end
        end
    end

    assign data = data_q;
endmodule

// File: rtl/rtc3w_master.sv
module rtc3w_master
    import rtc3w_pkg::*;
#(
    parameter int          HDIV_W      = 8,
    parameter int          ADDR_W      = 5,
    parameter int          BYTE_W      = 8,
    parameter int          BURST_BYTES = 8,
    parameter logic [4:0]  BURST_ADDR  = 5'h1F
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  logic [1:0]                      req_op,
    input  logic [ADDR_W-1:0]               req_addr,
    input  logic [BYTE_W*BURST_BYTES-1:0]   req_wdata,
    input  logic [HDIV_W-1:0]               half_div,
    output logic                            busy,
    output logic                            done,
    output logic [BYTE_W*BURST_BYTES-1:0]   rdata,
    output logic                            ce,
    output logic                            sclk,
    output logic                            dio_out,
    output logic                            dio_oe,
    input  logic                            dio_in
);
    localparam int DATA_W = BYTE_W * BURST_BYTES;
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam int BYC_W  = (BURST_BYTES > 1) ? $clog2(BURST_BYTES) : 1;
    localparam int IDX_W  = BIT_W + BYC_W;
    localparam int PAD_W  = BYTE_W - ADDR_W - 2;

    rtc3w_state_e            state_q, state_d;
    rtc3w_op_e               op;
    logic [BYTE_W-1:0]       cmd_q;
    logic [DATA_W-1:0]       wdat_q;
    logic                    rd_q;
    logic [BYC_W-1:0]        last_byte_q;
    logic [BIT_W-1:0]        bit_q;
    logic [BYC_W-1:0]        byte_q;
    logic                    gap_q;
    logic                    done_q;
    logic [DATA_W-1:0]       rdata_q;
    logic [DATA_W-1:0]       rx_data;
    logic                    tick, accept, last_bit, last_byte, is_rd, is_burst;
    logic [ADDR_W-1:0]       addr_eff;

    assign op        = rtc3w_op_e'(req_op);
    assign is_rd     = (op == OP_RD_ONE) || (op == OP_RD_BURST);
    assign is_burst  = (op == OP_WR_BURST) || (op == OP_RD_BURST);
    assign addr_eff  = is_burst ? ADDR_W'(BURST_ADDR) : req_addr;
    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign last_bit  = (bit_q == BIT_W'(BYTE_W - 1));
    assign last_byte = (byte_q == last_byte_q);

    rtc3w_tick #(.HDIV_W(HDIV_W)) tick_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q != ST_IDLE),
        .half_div (half_div),
        .tick     (tick)
    );

    rtc3w_rxcap #(.DATA_W(DATA_W), .IDX_W(IDX_W)) rxcap_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .cap   ((state_q == ST_RD_LO) && tick),
        .idx   ({byte_q, bit_q}),
        .din   (dio_in),
        .data  (rx_data)
    );

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_CMD_LO;
            ST_CMD_LO: if (tick) state_d = ST_CMD_HI;
            ST_CMD_HI: if (tick) state_d = !last_bit ? ST_CMD_LO
                                          : (rd_q ? ST_RD_LO : ST_WR_LO);
            ST_WR_LO:  if (tick) state_d = ST_WR_HI;
            ST_WR_HI:  if (tick) state_d = (last_bit && last_byte) ? ST_HOLD : ST_WR_LO;
            ST_RD_LO:  if (tick) state_d = ST_RD_HI;
            ST_RD_HI:  if (tick) state_d = (last_bit && last_byte) ? ST_HOLD : ST_RD_LO;
            ST_HOLD:   if (tick) state_d = ST_GAP;
            ST_GAP:    if (tick && gap_q) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cmd_q       <= '0;
            wdat_q      <= '0;
            rd_q        <= 1'b0;
            last_byte_q <= '0;
            bit_q       <= '0;
            byte_q      <= '0;
            gap_q       <= 1'b0;
            done_q      <= 1'b0;
            rdata_q     <= '0;
        end else begin
            state_q <= state_d;
            done_q  <= 1'b0;
            if (accept) begin
                cmd_q       <= {1'b1, {PAD_W{1'b0}}, addr_eff, is_rd};
                wdat_q      <= req_wdata;
                rd_q        <= is_rd;
                last_byte_q <= is_burst ? BYC_W'(BURST_BYTES - 1) : '0;
                bit_q       <= '0;
                byte_q      <= '0;
                gap_q       <= 1'b0;
            end else if (tick) begin
                case (state_q)
                    ST_CMD_HI: begin
                        cmd_q <= cmd_q >> 1;
                        bit_q <= last_bit ? '0 : bit_q + BIT_W'(1);
                    end
                    ST_WR_HI, ST_RD_HI: begin
                        if (state_q == ST_WR_HI) wdat_q <= wdat_q >> 1;
                        bit_q <= last_bit ? '0 : bit_q + BIT_W'(1);
                        if (last_bit) byte_q <= byte_q + BYC_W'(1);
                    end
                    ST_HOLD: begin
                        done_q  <= 1'b1;
                        rdata_q <= rx_data;
                    end
                    ST_GAP:  gap_q <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        ce      = 1'b0;
        sclk    = 1'b0;
        dio_oe  = 1'b0;
        dio_out = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_GAP: ;
            ST_CMD_LO, ST_CMD_HI: begin
                ce      = 1'b1;
                sclk    = (state_q == ST_CMD_HI);
                dio_oe  = 1'b1;
                dio_out = cmd_q[0];
            end
            ST_WR_LO, ST_WR_HI: begin
                ce      = 1'b1;
                sclk    = (state_q == ST_WR_HI);
                dio_oe  = 1'b1;
                dio_out = wdat_q[0];
            end
            ST_RD_LO, ST_RD_HI: begin
                ce   = 1'b1;
                sclk = (state_q == ST_RD_HI);
            end
            ST_HOLD: ce = 1'b1;
            default: ;
        endcase
    end

    assign busy  = (state_q != ST_IDLE);
    assign done  = done_q;
    assign rdata = rdata_q;
endmodule

// File: rtl/rtc3w_master_chk.sv
module rtc3w_master_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic ce,
    input logic sclk,
    input logic dio_out,
    input logic dio_oe
);
    // R8
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |-> !sclk);

    // R4
    dout_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk) && dio_oe) |-> $stable(dio_out));

    // R5
    oe_release_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dio_oe) |-> $fell(sclk));

    // R10
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R6
    ce_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce |-> busy);
endmodule

bind rtc3w_master rtc3w_master_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .ce        (ce),
    .sclk      (sclk),
    .dio_out   (dio_out),
    .dio_oe    (dio_oe)
);

// File: tb/rtc3w_master_tb.sv
module rtc3w_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  req_op;
    logic [4:0]  req_addr;
    logic [63:0] req_wdata;
    logic [7:0]  half_div;
    logic        busy, done, ce, sclk, dio_out, dio_oe;
    logic [63:0] rdata;
    logic        dio_in;

    always #10 clk = ~clk;

    rtc3w_master dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .half_div(half_div),
        .busy(busy), .done(done), .rdata(rdata), .ce(ce), .sclk(sclk),
        .dio_out(dio_out), .dio_oe(dio_oe), .dio_in(dio_in)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural chip model
    logic [7:0] mem [0:31];
    logic [7:0] cmd_seen = '0;
    logic [7:0] wbyte = '0;
    int nb = 0;
    int n_txn = 0;
    int contention = 0;

    function automatic int tgt_idx(input int byte_i);
        return (cmd_seen[5:1] == 5'h1F) ? byte_i : int'(cmd_seen[5:1]);
    endfunction

    always @(posedge ce) begin
        nb = 0;
        cmd_seen = '0;
        n_txn++;
    end

    always @(posedge sclk) if (ce) begin
        if (nb < 8) begin
            cmd_seen[nb] = dio_out;
            if (!dio_oe) contention++;
        end else if (!cmd_seen[0]) begin
            if (!dio_oe) contention++;
            wbyte[(nb - 8) % 8] = dio_out;
            if ((nb - 8) % 8 == 7) mem[tgt_idx((nb - 8) / 8)] = wbyte;
        end else if (dio_oe) begin
            contention++;
        end
        nb++;
    end

    always @(negedge sclk) if (ce && nb >= 8 && cmd_seen[0]) begin
        if (nb - 8 < 64) dio_in = mem[tgt_idx((nb - 8) / 8)][(nb - 8) % 8];
    end

    // cycle monitor
    int ce_cyc = 0, busy_cyc = 0, done_cnt = 0, done_wide = 0;
    logic done_prev = 1'b0;
    logic [63:0] cap_rdata = '0;

    always @(negedge clk) begin
        if (ce) ce_cyc++;
        if (busy) busy_cyc++;
        if (done) begin
            done_cnt++;
            cap_rdata = rdata;
            if (done_prev) done_wide++;
        end
        done_prev = done;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic run(input logic [1:0] op, input logic [4:0] addr,
                       input logic [63:0] wd, input bit poke);
        int t0, d0, nby, hde;
        logic [4:0] ae;
        nby = op[1] ? 8 : 1;
        hde = (half_div == 0) ? 1 : int'(half_div);
        ae  = op[1] ? 5'h1F : addr;
        ce_cyc = 0; busy_cyc = 0; done_wide = 0;
        t0 = n_txn; d0 = done_cnt;
        @(negedge clk);
        req_op = op; req_addr = addr; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            repeat (5) @(negedge clk);
            req_op = 2'd1; req_addr = 5'd9; req_wdata = '1; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        chk("R2 command byte", 64'(cmd_seen), 64'({1'b1, 1'b0, ae, op[0]}));
        chk("R6 clock edges while enabled", 64'(nb), 64'(8 + 8 * nby));
        chk("R7 enable-high cycles", 64'(ce_cyc), 64'((16 * nby + 17) * hde));
        chk("R8 enable-low gap cycles", 64'(busy_cyc - ce_cyc), 64'(2 * hde));
        chk("R9 one transaction per request", 64'(n_txn - t0), 64'd1);
        chk("R10 done count", 64'(done_cnt - d0), 64'd1);
        chk("R10 done width", 64'(done_wide), 64'd0);
        chk("R5 no line overlap", 64'(contention), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] expv [0:31];
        logic [63:0] exp_rd;
        rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0;
        req_wdata = '0; half_div = 8'd2; dio_in = 1'b0;
        for (int i = 0; i < 32; i++) begin
            mem[i] = 8'h00;
            expv[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {59'd0, ce, sclk, dio_oe, busy, done}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int hd = 0; hd < 4; hd++) begin
            half_div = 8'(hd);
            // R3 R4 single writes, junk in the upper bytes
            for (int a = 0; a < 31; a++) begin
                expv[a] = 8'((a * 37 + hd * 11 + 5) & 255);
                run(2'd0, 5'(a), {56'hA5A5_5A5A_C3C3_3C, expv[a]}, 1'b0);
                chk("R4 single write byte stored", 64'(mem[a]), 64'(expv[a]));
            end
            // R3 R5 single reads
            for (int a = 0; a < 31; a++) begin
                run(2'd1, 5'(a), '0, 1'b0);
                chk("R3 R5 single read data", cap_rdata, {56'd0, expv[a]});
            end
            // R2 R3 burst write with a non-burst address
            exp_rd = '0;
            for (int k = 0; k < 8; k++) exp_rd[8*k +: 8] = 8'((k * 29 + hd * 5 + 3) & 255);
            run(2'd2, 5'(hd + 4), exp_rd, 1'b0);
            for (int k = 0; k < 8; k++)
                chk("R3 burst write byte", 64'(mem[k]), 64'(exp_rd[8*k +: 8]));
            // R3 R5 burst read
            for (int k = 0; k < 8; k++) begin
                mem[k] = 8'((k * 53 + hd * 17 + 9) & 255);
                exp_rd[8*k +: 8] = mem[k];
            end
            run(2'd3, 5'(hd + 2), '0, 1'b0);
            chk("R3 R5 burst read data", cap_rdata, exp_rd);
            for (int k = 0; k < 8; k++) expv[k] = mem[k];
            // R9 request raised while busy is ignored
            expv[3] = 8'((hd * 71 + 13) & 255);
            run(2'd0, 5'd3, {56'd0, expv[3]}, 1'b1);
            chk("R9 running write kept", 64'(mem[3]), 64'(expv[3]));
            chk("R9 no trailing transaction", 64'(busy), 64'd0);
        end

        // R7 slowest-supply setting
        half_div = 8'd50;
        run(2'd0, 5'd20, 64'h5C, 1'b0);
        run(2'd1, 5'd20, '0, 1'b0);
        chk("R7 read back at slow rate", cap_rdata, 64'h5C);

        summary();
        $finish;
    end
endmodule